// File: doc/BRIEF.md
# Ethernet transmit frame builder

The block turns a packet, offered one byte at a time on a valid/ready stream with an end marker, into the byte sequence of a complete Ethernet frame. It puts the preamble and start-of-frame delimiter in front of the packet. It extends short data fields with zero bytes up to the minimum length. It then follows the data with a 32-bit frame check sequence. The output is a byte stream with a transmit-enable strobe, and it is meant to feed the logic that drives the PHY.

Each framing step can be turned off on its own through a configuration input. The check sequence is left off when either its configuration bit or a separate external pin is high. All of these controls are captured when a frame begins, and they are held for the whole frame.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and after it is released with no packet offered, `outEn` is 0, `outData` is 0x00 and `inReady` is 0.
- R2: When `cfgPreOff` is 0, a frame opens with seven bytes of 0x55 followed by one byte of 0xD5. When it is 1, the first output byte is the first packet byte.
- R3: Packet bytes leave in the order they were accepted, each one appearing on `outData` with `outEn` high in the cycle after the one in which `inValid` and `inReady` were both high.
- R4: When `cfgPadOn` is 1 and the packet has fewer than 46 bytes, zero bytes follow it until the data field holds exactly 46 bytes. A packet of 46 bytes or more, or any packet with `cfgPadOn` at 0, gets no padding.
- R5: The check sequence is CRC-32 with polynomial 0x04C11DB7, processed least-significant bit first. It starts from 0xFFFFFFFF and the result is inverted. It is computed over the data and pad bytes and never over the preamble or delimiter. It is sent least-significant byte first, so the nine-byte packet "123456789" ends with 0x26 0x39 0xF4 0xCB.
- R6: The check sequence is appended only when `cfgCrcOff` and `noCrcPin` are both 0. If either one is 1, the frame ends with its last data or pad byte.
- R7: The configuration inputs and `noCrcPin` are sampled in the cycle in which an idle block sees `inValid`. Changing them later in the frame has no effect on that frame.
- R8: `outEn` stays high without a break from the first output byte of a frame to its last one, provided the source keeps `inValid` high through the packet. After the last packet byte has been accepted, `inReady` stays low until the frame has been fully sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Packet byte offered |
| inData | input | 8 | Packet byte |
| inLast | input | 1 | Offered byte is the last of its packet |
| inReady | output | 1 | Block takes the offered byte this cycle |
| cfgPreOff | input | 1 | 1 = leave out preamble and delimiter |
| cfgPadOn | input | 1 | 1 = pad short data fields to 46 bytes |
| cfgCrcOff | input | 1 | 1 = leave out the check sequence |
| noCrcPin | input | 1 | External request to leave out the check sequence |
| outData | output | 8 | Frame byte |
| outEn | output | 1 | Transmit enable, qualifies `outData` |

## Verification
The bench aims at the length edges around 46 bytes: 45, 46, a single byte and long packets. A design that pads with an off-by-one would show as a frame one byte too long or too short, and a wrong check sequence would follow from the extra byte. It runs a known nine-byte packet against its published check value, which would expose a design that reflects the wrong way, skips the final inversion or sends the bytes in reverse order. It sets the configuration bit and the pin one at a time and together, which would catch an AND used where an OR is needed. It also changes every control partway through a frame, which would catch a design that reads the controls live instead of holding them.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS
  } txState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       crcInit;
    logic       sendPre;
    logic       sendSfd;
    logic       sendData;
    logic       sendPad;
    logic       sendFcs;
    logic [1:0] fcsIdx;
  } txStrobe_t;

  function automatic logic [31:0] reflect32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // one byte through an LSB-first CRC register
  function automatic logic [31:0] crcStep(input logic [31:0] c,
                                          input logic [7:0]  d,
                                          input logic [31:0] polyRef);
    logic [31:0] x;
    x = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) x = x[0] ? ((x >> 1) ^ polyRef) : (x >> 1);
    return x;
  endfunction

endpackage

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int PRE_LEN  = 7,
  parameter int MIN_DATA = 46
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  output logic      inReady,
  input  logic      cfgPreOff,
  input  logic      cfgPadOn,
  input  logic      cfgCrcOff,
  input  logic      noCrcPin,
  output txStrobe_t stb
);

  localparam int FCS_LEN = 4;
  localparam int W_DATA  = $clog2(MIN_DATA + 1);
  localparam int W_PRE   = $clog2(PRE_LEN + 1);
  localparam int W_A     = (W_DATA > W_PRE) ? W_DATA : W_PRE;
  localparam int CW      = (W_A > 2) ? W_A : 2;
  localparam logic [CW-1:0] PRE_C  = CW'(PRE_LEN);
  localparam logic [CW-1:0] MIN_C  = CW'(MIN_DATA);
  localparam logic [CW-1:0] PADE_C = CW'(MIN_DATA - 1);
  localparam logic [CW-1:0] FCSE_C = CW'(FCS_LEN - 1);

  txState_t      state, stateNxt;
  logic [CW-1:0] cnt, cntNxt, cntInc;
  logic          padOnL, crcOnL, latchCfg;

  assign cntInc = cnt + 1'b1;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    stb      = '0;
    inReady  = 1'b0;
    latchCfg = 1'b0;
    case (state)
      ST_IDLE: begin
        if (inValid) begin
          latchCfg    = 1'b1;
          stb.crcInit = 1'b1;
          cntNxt      = '0;
          stateNxt    = cfgPreOff ? ST_DATA : ST_PRE;
        end
      end
      ST_PRE: begin
        if (cnt == PRE_C) begin
          stb.sendSfd = 1'b1;
          cntNxt      = '0;
          stateNxt    = ST_DATA;
        end else begin
          stb.sendPre = 1'b1;
          cntNxt      = cntInc;
        end
      end
      ST_DATA: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.sendData = 1'b1;
          cntNxt       = (cnt == MIN_C) ? cnt : cntInc;
          if (inLast) begin
            if (padOnL && (cntNxt < MIN_C)) begin
              stateNxt = ST_PAD;
            end else if (crcOnL) begin
              cntNxt   = '0;
              stateNxt = ST_FCS;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
      end
      ST_PAD: begin
        stb.sendPad = 1'b1;
        if (cnt == PADE_C) begin
          cntNxt   = '0;
          stateNxt = crcOnL ? ST_FCS : ST_IDLE;
        end else begin
          cntNxt = cntInc;
        end
      end
      ST_FCS: begin
        stb.sendFcs = 1'b1;
        stb.fcsIdx  = cnt[1:0];
        if (cnt == FCSE_C) stateNxt = ST_IDLE;
        else               cntNxt   = cntInc;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      padOnL <= 1'b0;
      crcOnL <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (latchCfg) begin
        padOnL <= cfgPadOn;
        crcOnL <= !(cfgCrcOff || noCrcPin);
      end
    end
  end

endmodule

// File: rtl/eth_tx_dpath.sv
module eth_tx_dpath
  import eth_tx_pkg::*;
#(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t stb,
  input  logic [7:0] inData,
  output logic [7:0] outData,
  output logic      outEn
);

  localparam logic [31:0] POLY_REF = reflect32(POLY);
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;

  logic [31:0] crcReg, fcsWord;
  logic [7:0]  byteNxt;
  logic        enNxt;

  assign fcsWord = ~crcReg;
  assign enNxt   = stb.sendPre | stb.sendSfd | stb.sendData | stb.sendPad | stb.sendFcs;

  always_comb begin
    byteNxt = 8'h00;
    if (stb.sendPre)       byteNxt = PRE_BYTE;
    else if (stb.sendSfd)  byteNxt = SFD_BYTE;
    else if (stb.sendData) byteNxt = inData;
    else if (stb.sendFcs)  byteNxt = fcsWord[8*stb.fcsIdx +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= '1;
      outData <= 8'h00;
      outEn   <= 1'b0;
    end else begin
      outData <= byteNxt;
      outEn   <= enNxt;
      if (stb.crcInit)       crcReg <= '1;
      else if (stb.sendData) crcReg <= crcStep(crcReg, inData, POLY_REF);
      else if (stb.sendPad)  crcReg <= crcStep(crcReg, 8'h00, POLY_REF);
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int          PRE_LEN  = 7,
  parameter int          MIN_DATA = 46,
  parameter logic [31:0] POLY     = 32'h04C11DB7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inLast,
  output logic       inReady,
  input  logic       cfgPreOff,
  input  logic       cfgPadOn,
  input  logic       cfgCrcOff,
  input  logic       noCrcPin,
  output logic [7:0] outData,
  output logic       outEn
);

  txStrobe_t stb;

  eth_tx_ctrl #(.PRE_LEN(PRE_LEN), .MIN_DATA(MIN_DATA)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .cfgPreOff(cfgPreOff), .cfgPadOn(cfgPadOn), .cfgCrcOff(cfgCrcOff),
    .noCrcPin(noCrcPin), .stb(stb)
  );

  eth_tx_dpath #(.POLY(POLY)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .outData(outData), .outEn(outEn)
  );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk
  import eth_tx_pkg::*;
#(
  parameter int PRE_LEN  = 7,
  parameter int MIN_DATA = 46
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       inLast,
  input logic       inReady,
  input logic       cfgPreOff,
  input logic       cfgPadOn,
  input logic       cfgCrcOff,
  input logic       noCrcPin,
  input logic [7:0] outData,
  input logic       outEn,
  input txStrobe_t  stb
);

  logic       prevEn, tail;
  logic [7:0] run;
  logic       pendPre, pendPad, pendCrc;
  logic       actPre, actPad, actCrc;
  logic       rise, curPre;
  logic [7:0] pos;
  int         minRun;

  assign rise   = outEn && !prevEn;
  assign curPre = rise ? pendPre : actPre;
  assign pos    = rise ? 8'd0 : run;
  assign minRun = MIN_DATA + (actPre ? PRE_LEN + 1 : 0) + (actCrc ? 4 : 0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevEn <= 1'b0; tail <= 1'b0; run <= 8'd0;
      pendPre <= 1'b0; pendPad <= 1'b0; pendCrc <= 1'b0;
      actPre <= 1'b0; actPad <= 1'b0; actCrc <= 1'b0;
    end else begin
      prevEn <= outEn;
      if (outEn) run <= prevEn ? ((run == 8'hFF) ? run : run + 8'd1) : 8'd1;
      if (stb.crcInit) begin
        pendPre <= !cfgPreOff;
        pendPad <= cfgPadOn;
        pendCrc <= !(cfgCrcOff || noCrcPin);
      end
      if (rise) begin
        actPre <= pendPre; actPad <= pendPad; actCrc <= pendCrc;
      end
      if (inValid && inReady && inLast) tail <= 1'b1;
      else if (!outEn)                  tail <= 1'b0;
    end
  end

  assert_preamble_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && curPre && (pos < 8'(PRE_LEN))) |-> (outData == 8'h55));

  assert_sfd_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && curPre && (pos == 8'(PRE_LEN))) |-> (outData == 8'hD5));

  assert_data_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outEn && (outData == $past(inData))));

  assert_min_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outEn) && actPad) |-> (int'(run) >= minRun));

  assert_no_take_in_tail_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tail && outEn) |-> !inReady);

endmodule

bind eth_tx_framer eth_tx_framer_chk #(.PRE_LEN(PRE_LEN), .MIN_DATA(MIN_DATA)) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
  .inReady(inReady), .cfgPreOff(cfgPreOff), .cfgPadOn(cfgPadOn),
  .cfgCrcOff(cfgCrcOff), .noCrcPin(noCrcPin), .outData(outData), .outEn(outEn),
  .stb(stb)
);

// File: tb/eth_tx_framer_test.sv
module eth_tx_framer_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid, inLast, inReady;
  logic [7:0] inData;
  logic       cfgPreOff, cfgPadOn, cfgCrcOff, noCrcPin;
  logic [7:0] outData;
  logic       outEn;

  always #5 clk = ~clk;

  eth_tx_framer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inReady(inReady), .cfgPreOff(cfgPreOff), .cfgPadOn(cfgPadOn),
    .cfgCrcOff(cfgCrcOff), .noCrcPin(noCrcPin), .outData(outData), .outEn(outEn)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] pay [128];
  logic [7:0] got [256];
  logic [7:0] exp [256];
  int gotN, expN, gapCnt;

  // {len, seed, step, preOff, padOn, crcOff, pin}
  localparam int NVEC = 12;
  localparam logic [27:0] VEC [NVEC] = '{
    {8'd60, 8'h10, 8'd3,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'd10, 8'hA0, 8'd1,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'd10, 8'h5A, 8'd11, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'd46, 8'h01, 8'd5,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'd45, 8'hF0, 8'd7,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'd1,  8'h77, 8'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    {8'd20, 8'h33, 8'd9,  1'b0, 1'b1, 1'b1, 1'b0},
    {8'd20, 8'h33, 8'd9,  1'b0, 1'b1, 1'b0, 1'b1},
    {8'd20, 8'h33, 8'd9,  1'b0, 1'b1, 1'b1, 1'b1},
    {8'd8,  8'hC3, 8'd13, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'd64, 8'h00, 8'd1,  1'b1, 1'b1, 1'b1, 1'b0},
    {8'd3,  8'h80, 8'd2,  1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic string tagsFor(bit preOff, bit padOn, bit crcOff, bit pin);
    string s;
    s = preOff ? "R2(off) R3" : "R2 R3";
    if (padOn) s = {s, " R4"};
    s = (crcOff || pin) ? {s, " R6"} : {s, " R5"};
    return {s, " R8"};
  endfunction

  task automatic buildExp(input int len, input bit preOff, input bit padOn,
                          input bit crcOff, input bit pin);
    int st;
    logic [31:0] c;
    expN = 0;
    if (!preOff) begin
      for (int k = 0; k < 7; k++) exp[expN++] = 8'h55;
      exp[expN++] = 8'hD5;
    end
    st = expN;
    for (int k = 0; k < len; k++) exp[expN++] = pay[k];
    if (padOn) while (expN - st < 46) exp[expN++] = 8'h00;
    if (!(crcOff || pin)) begin
      c = 32'hFFFFFFFF;
      for (int k = st; k < expN; k++) begin
        c = c ^ {24'd0, exp[k]};
        for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      c = ~c;
      for (int k = 0; k < 4; k++) exp[expN++] = c[8*k +: 8];
    end
  endtask

  task automatic sendFrame(input int len, input bit midChange);
    int  idx = 0;
    int  guard = 0;
    int  lowRun = 0;
    bit  sent = 0;
    bit  seen = 0;
    bit  lowAfter = 0;
    gotN = 0;
    gapCnt = 0;
    while (guard < 3000 && !(idx == len && seen && lowRun >= 3)) begin
      @(negedge clk);
      guard++;
      if (sent) idx++;
      if (outEn) begin
        if (lowAfter) gapCnt++;
        lowAfter = 0;
        got[gotN++] = outData;
        seen = 1;
        lowRun = 0;
      end else begin
        if (seen) lowAfter = 1;
        lowRun++;
      end
      if (midChange && gotN == 3) begin
        cfgPreOff = ~cfgPreOff;
        cfgPadOn  = ~cfgPadOn;
        cfgCrcOff = 1'b1;
        noCrcPin  = 1'b1;
      end
      inValid = (idx < len);
      inData  = (idx < len) ? pay[idx] : 8'h00;
      inLast  = (idx == len - 1);
      sent    = inValid && inReady;
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    if (lowAfter && lowRun < 3) gapCnt++;
  endtask

  task automatic compareFrame(input string tag);
    int bad = -1;
    check(gotN == expN, tag, "frame length", gotN, expN);
    check(gapCnt == 0, "R8", "outEn gaps inside frame", gapCnt, 0);
    for (int k = 0; k < expN && k < gotN; k++)
      if (bad < 0 && got[k] != exp[k]) bad = k;
    if (bad >= 0) check(1'b0, tag, $sformatf("byte %0d", bad), got[bad], exp[bad]);
    else          check(1'b1, tag, "bytes", 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R8 watchdog: got %0d cycles expected under %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b1; inData = 8'hFF; inLast = 1'b0;
    cfgPreOff = 1'b0; cfgPadOn = 1'b1; cfgCrcOff = 1'b0; noCrcPin = 1'b0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check(outEn == 1'b0 && inReady == 1'b0 && outData == 8'h00, "R1", "in reset",
          {outEn, inReady, outData}, 0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset with nothing offered
    check(outEn == 1'b0 && inReady == 1'b0 && outData == 8'h00, "R1", "idle after reset",
          {outEn, inReady, outData}, 0);

    for (int v = 0; v < NVEC; v++) begin
      int len;
      logic [7:0] seed, step;
      len  = int'(VEC[v][27:20]);
      seed = VEC[v][19:12];
      step = VEC[v][11:4];
      {cfgPreOff, cfgPadOn, cfgCrcOff, noCrcPin} = VEC[v][3:0];
      for (int k = 0; k < len; k++) pay[k] = 8'(seed + k * step);
      sendFrame(len, 1'b0);
      buildExp(len, VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
      compareFrame(tagsFor(VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]));
    end

    // R5: known check value on "123456789", no preamble, no pad
    cfgPreOff = 1'b1; cfgPadOn = 1'b0; cfgCrcOff = 1'b0; noCrcPin = 1'b0;
    for (int k = 0; k < 9; k++) pay[k] = 8'(8'h31 + k);
    sendFrame(9, 1'b0);
    check(gotN == 13, "R5", "known vector length", gotN, 13);
    check({got[9], got[10], got[11], got[12]} == 32'h2639F4CB, "R5", "known vector fcs",
          {got[9], got[10], got[11], got[12]}, 32'h2639F4CB);

    // R7: controls changed during the frame leave it as it started
    cfgPreOff = 1'b0; cfgPadOn = 1'b1; cfgCrcOff = 1'b0; noCrcPin = 1'b0;
    for (int k = 0; k < 12; k++) pay[k] = 8'(8'h90 ^ k);
    sendFrame(12, 1'b1);
    buildExp(12, 1'b0, 1'b1, 1'b0, 1'b0);
    compareFrame("R7");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule